// File: doc/BRIEF.md
# Eight-Channel Periodic Tick Generator

This block produces periodic events on eight independent channels from a single bus clock. One shared 8-bit prescale counter divides the clock. Each time it passes zero, every running channel decrements its own 16-bit counter. When a channel counter is already at zero on such a tick, the channel times out. Its counter reloads from the channel's load value, a one-cycle trigger pulse goes out on that channel's trigger line, and a sticky flag bit is set. An interrupt output is raised while any flag is set whose interrupt enable bit is also set.

Software drives the block through a single-cycle write port and a combinational read port. It sets the prescale load, the channel loads, the run mask and the interrupt mask. It clears flags by writing ones, and it can restart counting at once with a force strobe. The period of a channel, in bus clocks, is (prescale load + 1) × (channel load + 1). Periods shorter than two clocks are not supported, because a trigger pulse then cannot return low.

Top module: `periodic_tick_bank`

## Requirements
- R1: After reset every register reads zero, all trigger lines are low and the interrupt output is low.
- R2: When a channel is enabled while the other channels are stopped, its first trigger pulse rises exactly (P+1)×(C+1) clock edges after the enabling write edge. P is the prescale load and C is the channel load. The pulse is high for one cycle.
- R3: A running channel repeats its trigger every (P+1)×(C+1) clock edges.
- R4: A channel counter steps only on the cycle in which the shared prescaler is at zero. A trigger therefore always follows a prescaler tick in the cycle before it.
- R5: A flag bit (bit i at address 2) is set on the same edge at which trigger i rises.
- R6: A flag clears only when a one is written to its bit at address 2, and a zero bit leaves it unchanged. A set and a clear on the same edge leave the flag set.
- R7: The interrupt output is high exactly while some channel has both its flag bit and its interrupt-enable bit (bit i at address 1) set.
- R8: A channel whose enable bit (bit i at address 0) is clear keeps its trigger low and never sets its flag. While disabled, its counter stays at its load value, so a later enable starts a full period.
- R9: A write to address 3 restarts counting. Bit i reloads channel i, and bit 15 reloads the prescaler. When both are written, the next trigger of channel i comes (P+1)×(C+1) edges after that write.
- R10: Register map: 0 enable mask, 1 interrupt-enable mask, 2 flags, 3 force strobe (reads zero), 4 prescale load (8 bits), 8+i load of channel i (16 bits). Each of these reads back what was written.
- R11: Channels enabled together with different loads each keep their own period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| trig | output | 8 | Per-channel one-cycle trigger pulses |
| irq | output | 1 | Interrupt request |

## Verification
The main stimulus is a sweep over prescale loads 0 to 3 and channel loads 0 to 3, rotating across the channels, with every period of two or more clocks included. For each pair, both the latency from enable to the first trigger and the repeat interval are measured. This separates an off-by-one in the prescaler from one in the channel counter, since each error scales the product differently. A force applied partway through a long period shows whether the restart reloads both stages or only one. Two channels running at once with unequal loads expose any crosstalk through the shared prescaler. A clear written on exactly the edge at which a flag is set checks the set-over-clear priority.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
  localparam int REG_ENABLE  = 0;
  localparam int REG_IRQEN   = 1;
  localparam int REG_FLAGS   = 2;
  localparam int REG_FORCE   = 3;
  localparam int REG_PRELOAD = 4;
  localparam int REG_CHBASE  = 8;

  // count down one step, wrapping to the reload value after zero
  function automatic logic [31:0] step_down(input logic [31:0] cnt,
                                            input logic [31:0] ld);
    return (cnt == 32'd0) ? ld : cnt - 32'd1;
  endfunction

  function automatic logic at_zero(input logic [31:0] cnt);
    return cnt == 32'd0;
  endfunction
endpackage

// File: rtl/ptb_regs.sv
module ptb_regs
  import ptb_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int CNT_W  = 16,
  parameter int MT_W   = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [DATA_W-1:0]           rd_data,
  input  logic [NCH-1:0]              set_mask,
  output logic [NCH-1:0]              en_q,
  output logic [NCH-1:0]              ie_q,
  output logic [NCH-1:0]              flag_q,
  output logic [MT_W-1:0]             mt_ld_q,
  output logic [NCH-1:0][CNT_W-1:0]   ch_ld_q,
  output logic [NCH-1:0]              force_ch,
  output logic                        force_mt,
  output logic [NCH-1:0]              clr_mask
);
  localparam int FORCE_MT_BIT = DATA_W - 1;

  logic hit_en, hit_ie, hit_flag, hit_force, hit_pre;

  always_comb begin
    hit_en    = wr_en && (wr_addr == ADDR_W'(REG_ENABLE));
    hit_ie    = wr_en && (wr_addr == ADDR_W'(REG_IRQEN));
    hit_flag  = wr_en && (wr_addr == ADDR_W'(REG_FLAGS));
    hit_force = wr_en && (wr_addr == ADDR_W'(REG_FORCE));
    hit_pre   = wr_en && (wr_addr == ADDR_W'(REG_PRELOAD));
    clr_mask  = hit_flag  ? wr_data[NCH-1:0] : '0;
    force_ch  = hit_force ? wr_data[NCH-1:0] : '0;
    force_mt  = hit_force && wr_data[FORCE_MT_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      ie_q    <= '0;
      flag_q  <= '0;
      mt_ld_q <= '0;
    end else begin
      if (hit_en)  en_q    <= wr_data[NCH-1:0];
      if (hit_ie)  ie_q    <= wr_data[NCH-1:0];
      if (hit_pre) mt_ld_q <= wr_data[MT_W-1:0];
      // a new time-out wins over a clear on the same edge
      flag_q <= (flag_q & ~clr_mask) | set_mask;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ld
    always_ff @(posedge clk) begin
      if (!rst_n)
        ch_ld_q[g] <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(REG_CHBASE + g)))
        ch_ld_q[g] <= wr_data[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(REG_ENABLE))  rd_data = DATA_W'(en_q);
    if (rd_addr == ADDR_W'(REG_IRQEN))   rd_data = DATA_W'(ie_q);
    if (rd_addr == ADDR_W'(REG_FLAGS))   rd_data = DATA_W'(flag_q);
    if (rd_addr == ADDR_W'(REG_PRELOAD)) rd_data = DATA_W'(mt_ld_q);
    for (int i = 0; i < NCH; i++)
      if (rd_addr == ADDR_W'(REG_CHBASE + i)) rd_data = DATA_W'(ch_ld_q[i]);
  end
endmodule

// File: rtl/ptb_prescaler.sv
module ptb_prescaler
  import ptb_pkg::*;
#(
  parameter int MT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            force_ld,
  input  logic [MT_W-1:0] ld,
  output logic            tick
);
  logic [MT_W-1:0] cnt_q;

  always_comb tick = run && !force_ld && at_zero(32'(cnt_q));

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run || force_ld)
      cnt_q <= ld;
    else
      cnt_q <= MT_W'(step_down(32'(cnt_q), 32'(ld)));
  end
endmodule

// File: rtl/ptb_channel.sv
module ptb_channel
  import ptb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             force_ld,
  input  logic             tick,
  input  logic [CNT_W-1:0] ld,
  output logic             timeout,
  output logic             trig
);
  logic [CNT_W-1:0] cnt_q;

  always_comb timeout = en && tick && !force_ld && at_zero(32'(cnt_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      trig  <= 1'b0;
    end else begin
      trig <= timeout;
      if (!en || force_ld)
        cnt_q <= ld;
      else if (tick)
        cnt_q <= CNT_W'(step_down(32'(cnt_q), 32'(ld)));
    end
  end
endmodule

// File: rtl/periodic_tick_bank.sv
module periodic_tick_bank
  import ptb_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int CNT_W  = 16,
  parameter int MT_W   = 8,
  parameter int DATA_W = CNT_W,
  parameter int ADDR_W = $clog2(REG_CHBASE + NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NCH-1:0]    trig,
  output logic              irq
);
  logic [NCH-1:0]            en_q, ie_q, flag_q, force_ch, clr_mask, timeout;
  logic [MT_W-1:0]           mt_ld_q;
  logic [NCH-1:0][CNT_W-1:0] ch_ld_q;
  logic                      force_mt, mt_tick;

  ptb_regs #(
    .NCH(NCH), .CNT_W(CNT_W), .MT_W(MT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .set_mask(timeout), .en_q(en_q), .ie_q(ie_q), .flag_q(flag_q),
    .mt_ld_q(mt_ld_q), .ch_ld_q(ch_ld_q), .force_ch(force_ch),
    .force_mt(force_mt), .clr_mask(clr_mask)
  );

  ptb_prescaler #(.MT_W(MT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(|en_q), .force_ld(force_mt),
    .ld(mt_ld_q), .tick(mt_tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ptb_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .en(en_q[g]), .force_ld(force_ch[g]),
      .tick(mt_tick), .ld(ch_ld_q[g]), .timeout(timeout[g]), .trig(trig[g])
    );
  end

  always_comb irq = |(flag_q & ie_q);
endmodule

// File: rtl/ptb_checker.sv
module ptb_checker #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] en_q,
  input logic [NCH-1:0] ie_q,
  input logic [NCH-1:0] flag_q,
  input logic [NCH-1:0] clr_mask,
  input logic [NCH-1:0] trig,
  input logic           mt_tick,
  input logic           irq
);
  AST_TRIG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (trig & ~$past(en_q)) == '0);                                    // R8
  AST_TRIG_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig) |-> $past(mt_tick));                                     // R4
  AST_TRIG_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (trig & ~flag_q) == '0);                                         // R5
  AST_FLAG_CLEAR_ONLY_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flag_q) & ~flag_q) & ~$past(clr_mask)) == '0);           // R6
  AST_IRQ_QUIET_NO_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q == '0) |-> !irq);                                          // R7
  AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !mt_tick);                                      // R4
endmodule

bind periodic_tick_bank ptb_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .ie_q(ie_q), .flag_q(flag_q),
  .clr_mask(clr_mask), .trig(trig), .mt_tick(mt_tick), .irq(irq)
);

// File: tb/sim_periodic_tick_bank.sv
`timescale 1ns/1ps
module sim_periodic_tick_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [7:0]  trig;
  logic        irq;
  int checks = 0;
  int fails = 0;

  periodic_tick_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .trig(trig), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    rd_addr = 4'(a);
    #0.5 d = int'(rd_data);
  endtask

  // counts edges until trig[ch] is seen high just after an edge
  task automatic wait_trig(input int ch, output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      #1;
    end while (!trig[ch] && n < 4000);
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int v, n, per, k, c1, c2;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1 trig", int'(trig), 0);
    chk("R1 irq", int'(irq), 0);
    foreach (v_addr[i]) ;
    rd(0, v); chk("R1 enable", v, 0);
    rd(1, v); chk("R1 irqen", v, 0);
    rd(2, v); chk("R1 flags", v, 0);
    rd(4, v); chk("R1 preload", v, 0);
    rd(11, v); chk("R1 ch3 load", v, 0);

    // R10 register readback
    wr(11, 16'h1234); rd(11, v); chk("R10 ch3 load", v, 16'h1234);
    wr(4, 16'h01A5);  rd(4, v);  chk("R10 preload 8-bit", v, 16'h00A5);
    wr(1, 16'h00C3);  rd(1, v);  chk("R10 irqen", v, 16'h00C3);
    wr(3, 16'h80FF);  rd(3, v);  chk("R10 force reads zero", v, 0);
    wr(1, 0);

    // R2 R3 R5 sweep over prescale and channel loads
    k = 0;
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 4; c++) begin
        if ((m + 1) * (c + 1) < 2) continue;
        per = (m + 1) * (c + 1);
        wr(0, 0); wr(2, 16'hFF);
        wr(4, m); wr(8 + k, c);
        wr(0, 1 << k);
        wait_trig(k, n); chk($sformatf("R2 first m=%0d c=%0d ch=%0d", m, c, k), n, per);
        rd(2, v); chk("R5 flag with trigger", (v >> k) & 1, 1);
        wait_trig(k, n); chk($sformatf("R3 period m=%0d c=%0d", m, c), n, per);
        @(posedge clk); #1 chk("R2 pulse one cycle", int'(trig[k]), 0);
        k = (k + 1) % 8;
      end
    end

    // R6 write-one-to-clear, zero has no effect, set wins
    wr(0, 0); wr(2, 16'hFF);
    wr(4, 0); wr(8, 1); wr(0, 1);          // enable edge E0, events at E0+2, E0+4
    @(posedge clk); @(posedge clk); @(posedge clk);
    #1 rd(2, v); chk("R6 flag set before zero write", v & 1, 1);
    wr(2, 16'h0000);                       // at E0+4, zero bit: no effect
    rd(2, v); chk("R6 zero write ignored", v & 1, 1);
    wr(2, 16'h0001);                       // at E0+5: no set pending
    rd(2, v); chk("R6 one clears", v & 1, 0);
    @(posedge clk);                        // E0+6: set
    wr(2, 16'h0001);                       // E0+7: clear
    wr(2, 16'h0001);                       // E0+8: clear and set together
    rd(2, v); chk("R6 set wins over clear", v & 1, 1);

    // R7 interrupt masking
    wr(0, 0); wr(2, 16'hFF); wr(1, 0);
    wr(4, 1); wr(9, 2); wr(0, 16'h02);
    wait_trig(1, n);
    #0.5 chk("R7 irq low with ie clear", int'(irq), 0);
    wr(0, 0); wr(1, 16'h01);
    #0.5 chk("R7 irq low, other channel ie", int'(irq), 0);
    wr(1, 16'h02);
    #0.5 chk("R7 irq high", int'(irq), 1);
    wr(2, 16'h02);
    #0.5 chk("R7 irq low after clear", int'(irq), 0);
    wr(1, 0);

    // R8 disabled channels stay silent
    wr(4, 0); wr(8, 1); wr(9, 1); wr(2, 16'hFF);
    c1 = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); #1 if (trig != 0) c1++;
    end
    chk("R8 no trigger while disabled", c1, 0);
    rd(2, v); chk("R8 no flag while disabled", v, 0);

    // R9 force restart of both stages
    wr(4, 3); wr(8, 9); wr(0, 1);
    repeat (15) @(posedge clk);
    wr(3, 16'h8001);
    wait_trig(0, n); chk("R9 force restart", n, 40);
    wait_trig(0, n); chk("R9 period after force", n, 40);

    // R11 independent channels sharing the prescaler
    wr(0, 0); wr(4, 1); wr(9, 2); wr(10, 4);
    wr(0, 16'h06);
    c1 = 0; c2 = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); #1;
      if (trig[1]) c1++;
      if (trig[2]) c2++;
    end
    chk("R11 ch1 pulses", c1, 10);
    chk("R11 ch2 pulses", c2, 6);
    wr(0, 0);

    summary();
  end

  int v_addr[1];
endmodule